// File: doc/BRIEF.md
# Floating-Point Register Narrow-Value Boxing Unit

This unit sits between a 64-bit floating-point register file and the single- and double-precision datapaths. Every single-precision value written into a register, whether an arithmetic result or a load, has its upper half filled with ones. Every single-precision operand read from the register file is checked: if its upper half is not all ones, the datapath receives a canonical single-precision NaN in boxed form. Double-precision traffic passes through untouched. Single-precision stores send only the low word to memory.

The unit also keeps the floating-point context state (off, initial, clean, dirty) and a summary-dirty flag. It keeps one copy for the running context and one for the hypervisor. When the context is off, any floating-point request is refused as illegal and nothing is written. An accepted register write marks the running copy dirty on the next clock edge. When virtualization is active, the same write also marks the hypervisor copy dirty. Either copy can be loaded with a new state value through a small load port.

Top module: `fpbox_unit`

## Requirements
- R1: An accepted register write with `req_single`=1 drives `rf_wdata` with bits 63:32 all ones and bits 31:0 equal to `req_wdata[31:0]`. This applies to request kind 0 (arithmetic with write) and kind 1 (load).
- R2: An accepted register write with `req_single`=0 drives `rf_wdata` equal to `req_wdata` on all 64 bits.
- R3: On a read port with its single flag set, an operand whose bits 63:32 are all ones is passed to `rd_val` unchanged.
- R4: On a read port with its single flag set, an operand whose bits 63:32 are not all ones is replaced on `rd_val` by 0xFFFFFFFF7FC00000.
- R5: On a read port with its single flag clear, `rd_val` equals the raw operand on all 64 bits.
- R6: With `st_single`=1, `mem_wdata` is zero in bits 63:32 and carries `st_raw[31:0]` in bits 31:0, with no check of the upper half. With `st_single`=0, `mem_wdata` equals `st_raw`.
- R7: While `ctx_main` is 0 (off), any valid request raises `illegal`, keeps `rf_we` low and leaves both context copies unchanged. Context encoding: 0 off, 1 initial, 2 clean, 3 dirty.
- R8: An accepted write of kind 0 or 1 sets `ctx_main` to 3 and `sd_main` to 1 at the next clock edge. Kind 2 (store) and kind 3 (arithmetic without FP write) never assert `rf_we` and leave the context unchanged.
- R9: An accepted write made while `virt_on`=1 also sets `ctx_hyp` to 3 and `sd_hyp` to 1 at the next edge. With `virt_on`=0, the hypervisor copy is not touched.
- R10: Synchronous reset places both context copies at 0 and both summary flags at 0.
- R11: `stat_wr_sel` bit 0 (running copy) and bit 1 (hypervisor copy) load `stat_wr_val` at the next edge. The summary flag of a loaded copy becomes 1 only if the loaded value is 3. If a dirty marking falls in the same cycle as a load, the dirty marking wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Floating-point request present this cycle |
| req_kind | input | 2 | 0 arith with write, 1 load, 2 store, 3 arith without FP write |
| req_single | input | 1 | Request is single precision |
| req_wdata | input | FLEN | Result or load data to be written |
| virt_on | input | 1 | Virtualization active |
| rd_raw | input | NRD*FLEN | Raw register operands, port p at bits p*FLEN |
| rd_single | input | NRD | Per-port single-precision read flag |
| rd_val | output | NRD*FLEN | Checked operands to the datapath |
| st_raw | input | FLEN | Register value being stored |
| st_single | input | 1 | Store is single precision |
| mem_wdata | output | FLEN | Data sent to memory |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | FLEN | Register file write data |
| illegal | output | 1 | Request refused, context off |
| stat_wr_sel | input | 2 | Load select: bit 0 running copy, bit 1 hypervisor copy |
| stat_wr_val | input | 2 | Context value to load |
| ctx_main | output | 2 | Running context state |
| sd_main | output | 1 | Running summary-dirty flag |
| ctx_hyp | output | 2 | Hypervisor context state |
| sd_hyp | output | 1 | Hypervisor summary-dirty flag |

## Verification
The bench builds the unit with its defaults: a 64-bit register width, three read ports and the standard quiet-NaN pattern. With three ports, one vector table can be rotated across all of them, so valid boxes, broken boxes and wide operands are mixed in the same cycle, including words with a single cleared bit at either end of the upper half. Directed sequences then walk the context copies through off, loaded, dirty and reset. They cover a write and a load landing together and both settings of the virtualization flag.

// File: rtl/fpbox_pkg.sv
package fpbox_pkg;

    localparam int SP_W = 32;

    typedef enum logic [1:0] {
        REQ_ARITH_WR   = 2'd0,
        REQ_LOAD       = 2'd1,
        REQ_STORE      = 2'd2,
        REQ_ARITH_NOWR = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        CTX_OFF     = 2'd0,
        CTX_INITIAL = 2'd1,
        CTX_CLEAN   = 2'd2,
        CTX_DIRTY   = 2'd3
    } ctx_state_e;

    typedef struct packed {
        ctx_state_e state;
        logic       summary;
    } ctx_status_t;

    function automatic logic kind_writes_reg(req_kind_e k);
        return (k == REQ_ARITH_WR) || (k == REQ_LOAD);
    endfunction

endpackage

// File: rtl/fpbox_write_path.sv
module fpbox_write_path
    import fpbox_pkg::*;
#(
    parameter int FLEN = 64
) (
    input  logic            valid,
    input  req_kind_e       kind,
    input  logic            single,
    input  logic            allow,
    input  logic [FLEN-1:0] data,
    output logic            we,
    output logic [FLEN-1:0] wdata
);
    localparam int HI_W = FLEN - SP_W;

    always_comb begin
        we = valid && allow && kind_writes_reg(kind);
        if (single) begin
            wdata = {{HI_W{1'b1}}, data[SP_W-1:0]};
        end else begin
            wdata = data;
        end
    end
endmodule

// File: rtl/fpbox_read_check.sv
module fpbox_read_check
    import fpbox_pkg::*;
#(
    parameter int          FLEN        = 64,
    parameter logic [31:0] CANON_NAN_S = 32'h7FC0_0000
) (
    input  logic [FLEN-1:0] raw,
    input  logic            single,
    output logic [FLEN-1:0] val
);
    localparam int HI_W = FLEN - SP_W;
    localparam logic [FLEN-1:0] BOXED_NAN = {{HI_W{1'b1}}, CANON_NAN_S};

    logic box_ok;

    always_comb begin
        box_ok = &raw[FLEN-1:SP_W];
        if (single && !box_ok) begin
            val = BOXED_NAN;
        end else begin
            val = raw;
        end
    end
endmodule

// File: rtl/fpbox_status_copy.sv
module fpbox_status_copy
    import fpbox_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mark_dirty,
    input  logic        load_en,
    input  logic [1:0]  load_val,
    output ctx_status_t status
);
    ctx_status_t status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q.state   <= CTX_OFF;
            status_q.summary <= 1'b0;
        end else if (mark_dirty) begin
            status_q.state   <= CTX_DIRTY;
            status_q.summary <= 1'b1;
        end else if (load_en) begin
            status_q.state   <= ctx_state_e'(load_val);
            status_q.summary <= (load_val == 2'd3);
        end
    end

    assign status = status_q;
endmodule

// File: rtl/fpbox_unit.sv
module fpbox_unit
    import fpbox_pkg::*;
#(
    parameter int          FLEN        = 64,
    parameter int          NRD         = 3,
    parameter logic [31:0] CANON_NAN_S = 32'h7FC0_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic                req_single,
    input  logic [FLEN-1:0]     req_wdata,
    input  logic                virt_on,
    input  logic [NRD*FLEN-1:0] rd_raw,
    input  logic [NRD-1:0]      rd_single,
    output logic [NRD*FLEN-1:0] rd_val,
    input  logic [FLEN-1:0]     st_raw,
    input  logic                st_single,
    output logic [FLEN-1:0]     mem_wdata,
    output logic                rf_we,
    output logic [FLEN-1:0]     rf_wdata,
    output logic                illegal,
    input  logic [1:0]          stat_wr_sel,
    input  logic [1:0]          stat_wr_val,
    output logic [1:0]          ctx_main,
    output logic                sd_main,
    output logic [1:0]          ctx_hyp,
    output logic                sd_hyp
);
    localparam int HI_W    = FLEN - SP_W;
    localparam int NCOPIES = 2;

    ctx_status_t copy_st [NCOPIES];
    logic        mark    [NCOPIES];
    logic        wr_acc;

    assign illegal = req_valid && (copy_st[0].state == CTX_OFF);

    fpbox_write_path #(.FLEN(FLEN)) i_wr (
        .valid  (req_valid),
        .kind   (req_kind_e'(req_kind)),
        .single (req_single),
        .allow  (!illegal),
        .data   (req_wdata),
        .we     (wr_acc),
        .wdata  (rf_wdata)
    );
    assign rf_we = wr_acc;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        fpbox_read_check #(.FLEN(FLEN), .CANON_NAN_S(CANON_NAN_S)) i_chk (
            .raw    (rd_raw[p*FLEN +: FLEN]),
            .single (rd_single[p]),
            .val    (rd_val[p*FLEN +: FLEN])
        );
    end

    assign mem_wdata = st_single ? {{HI_W{1'b0}}, st_raw[SP_W-1:0]} : st_raw;

    for (genvar g = 0; g < NCOPIES; g++) begin : g_ctx
        if (g == 0) begin : g_main
            assign mark[g] = wr_acc;
        end else begin : g_hyp
            assign mark[g] = wr_acc && virt_on;
        end
        fpbox_status_copy i_copy (
            .clk        (clk),
            .rst        (rst),
            .mark_dirty (mark[g]),
            .load_en    (stat_wr_sel[g]),
            .load_val   (stat_wr_val),
            .status     (copy_st[g])
        );
    end

    assign ctx_main = copy_st[0].state;
    assign sd_main  = copy_st[0].summary;
    assign ctx_hyp  = copy_st[1].state;
    assign sd_hyp   = copy_st[1].summary;
endmodule

// File: rtl/fpbox_unit_chk.sv
module fpbox_unit_chk #(
    parameter int          FLEN        = 64,
    parameter int          NRD         = 3,
    parameter logic [31:0] CANON_NAN_S = 32'h7FC0_0000
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [1:0]          req_kind,
    input logic                req_single,
    input logic [FLEN-1:0]     req_wdata,
    input logic                virt_on,
    input logic [NRD*FLEN-1:0] rd_raw,
    input logic [NRD-1:0]      rd_single,
    input logic [NRD*FLEN-1:0] rd_val,
    input logic                st_single,
    input logic [FLEN-1:0]     mem_wdata,
    input logic                rf_we,
    input logic [FLEN-1:0]     rf_wdata,
    input logic                illegal,
    input logic                ld_main,
    input logic [1:0]          stat_wr_val,
    input logic [1:0]          ctx_main,
    input logic                sd_main,
    input logic [1:0]          ctx_hyp
);
    localparam int HI_W = FLEN - 32;
    localparam logic [FLEN-1:0] BOXED_NAN = {{HI_W{1'b1}}, CANON_NAN_S};

    assert_box_upper_R1: assert property (@(posedge clk) disable iff (rst)
        (rf_we && req_single) |-> (&rf_wdata[FLEN-1:32] && rf_wdata[31:0] == req_wdata[31:0]));

    assert_wide_write_R2: assert property (@(posedge clk) disable iff (rst)
        (rf_we && !req_single) |-> (rf_wdata == req_wdata));

    for (genvar p = 0; p < NRD; p++) begin : g_port
        assert_good_box_R3: assert property (@(posedge clk) disable iff (rst)
            (rd_single[p] && &rd_raw[p*FLEN+32 +: HI_W]) |-> (rd_val[p*FLEN +: FLEN] == rd_raw[p*FLEN +: FLEN]));
        assert_nan_subst_R4: assert property (@(posedge clk) disable iff (rst)
            (rd_single[p] && !(&rd_raw[p*FLEN+32 +: HI_W])) |-> (rd_val[p*FLEN +: FLEN] == BOXED_NAN));
        assert_wide_read_R5: assert property (@(posedge clk) disable iff (rst)
            !rd_single[p] |-> (rd_val[p*FLEN +: FLEN] == rd_raw[p*FLEN +: FLEN]));
    end

    assert_store_low_R6: assert property (@(posedge clk) disable iff (rst)
        st_single |-> (mem_wdata[FLEN-1:32] == '0));

    assert_off_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !rf_we);

    assert_dirty_mark_R8: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> (ctx_main == 2'd3 && sd_main));

    assert_store_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2 && !ld_main) |=> $stable(ctx_main));

    assert_virt_dirty_R9: assert property (@(posedge clk) disable iff (rst)
        (rf_we && virt_on) |=> (ctx_hyp == 2'd3));

    assert_load_main_R11: assert property (@(posedge clk) disable iff (rst)
        (ld_main && !rf_we) |=> (ctx_main == $past(stat_wr_val)));
endmodule

bind fpbox_unit fpbox_unit_chk #(.FLEN(FLEN), .NRD(NRD), .CANON_NAN_S(CANON_NAN_S)) i_fpbox_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_single  (req_single),
    .req_wdata   (req_wdata),
    .virt_on     (virt_on),
    .rd_raw      (rd_raw),
    .rd_single   (rd_single),
    .rd_val      (rd_val),
    .st_single   (st_single),
    .mem_wdata   (mem_wdata),
    .rf_we       (rf_we),
    .rf_wdata    (rf_wdata),
    .illegal     (illegal),
    .ld_main     (stat_wr_sel[0]),
    .stat_wr_val (stat_wr_val),
    .ctx_main    (ctx_main),
    .sd_main     (sd_main),
    .ctx_hyp     (ctx_hyp)
);

// File: tb/test_fpbox_unit.sv
module test_fpbox_unit;
    localparam int FLEN = 64;
    localparam int NRD  = 3;
    localparam int NVEC = 8;
    localparam logic [63:0] NAN_BOX = 64'hFFFF_FFFF_7FC0_0000;

    // entry = {single, raw, expected}
    localparam logic [128:0] RD_TAB [NVEC] = '{
        {1'b1, 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_3F80_0000},
        {1'b1, 64'h0000_0000_3F80_0000, NAN_BOX},
        {1'b1, 64'h7FFF_FFFF_1234_5678, NAN_BOX},
        {1'b1, 64'hFFFF_FFFE_ABCD_EF01, NAN_BOX},
        {1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000},
        {1'b0, 64'h4009_21FB_5444_2D18, 64'h4009_21FB_5444_2D18},
        {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000}
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic [1:0]          req_kind = 2'd0;
    logic                req_single = 1'b0;
    logic [FLEN-1:0]     req_wdata = '0;
    logic                virt_on = 1'b0;
    logic [NRD*FLEN-1:0] rd_raw = '0;
    logic [NRD-1:0]      rd_single = '0;
    logic [NRD*FLEN-1:0] rd_val;
    logic [FLEN-1:0]     st_raw = '0;
    logic                st_single = 1'b0;
    logic [FLEN-1:0]     mem_wdata;
    logic                rf_we;
    logic [FLEN-1:0]     rf_wdata;
    logic                illegal;
    logic [1:0]          stat_wr_sel = 2'd0;
    logic [1:0]          stat_wr_val = 2'd0;
    logic [1:0]          ctx_main;
    logic                sd_main;
    logic [1:0]          ctx_hyp;
    logic                sd_hyp;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    fpbox_unit #(.FLEN(FLEN), .NRD(NRD)) i_fpbox_unit (.*);

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic ctx_state(input string tag, input logic [1:0] em, input logic es, input logic [1:0] eh, input logic ehs);
        chk_eq({tag, " ctx_main"}, {62'd0, ctx_main}, {62'd0, em});
        chk_eq({tag, " sd_main"},  {63'd0, sd_main},  {63'd0, es});
        chk_eq({tag, " ctx_hyp"},  {62'd0, ctx_hyp},  {62'd0, eh});
        chk_eq({tag, " sd_hyp"},   {63'd0, sd_hyp},   {63'd0, ehs});
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        ctx_state("R10 reset", 2'd0, 1'b0, 2'd0, 1'b0);

        // R3 R4 R5: rotate the table across all read ports
        for (int i = 0; i < NVEC; i++) begin
            for (int p = 0; p < NRD; p++) begin
                rd_single[p] = RD_TAB[(i + p) % NVEC][128];
                rd_raw[p*FLEN +: FLEN] = RD_TAB[(i + p) % NVEC][127:64];
            end
            #2;
            for (int p = 0; p < NRD; p++) begin
                logic [128:0] v;
                string tag;
                v = RD_TAB[(i + p) % NVEC];
                tag = !v[128] ? "R5 wide read" : (v[127:64] == v[63:0]) ? "R3 boxed read" : "R4 nan substitution";
                chk_eq(tag, rd_val[p*FLEN +: FLEN], v[63:0]);
            end
            @(negedge clk);
        end
        rd_single = '0;

        // R6 store data
        st_single = 1'b1; st_raw = 64'h1234_5678_CAFE_F00D; #2;
        chk_eq("R6 single store", mem_wdata, 64'h0000_0000_CAFE_F00D);
        st_single = 1'b0; #2;
        chk_eq("R6 double store", mem_wdata, 64'h1234_5678_CAFE_F00D);

        // R7 context off refuses request
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_single = 1'b1; req_wdata = 64'h0000_0000_1111_2222; #2;
        chk_eq("R7 illegal", {63'd0, illegal}, 64'd1);
        chk_eq("R7 no write", {63'd0, rf_we}, 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        ctx_state("R7 unchanged", 2'd0, 1'b0, 2'd0, 1'b0);

        // R11 load both copies
        stat_wr_sel = 2'b01; stat_wr_val = 2'd1;
        @(negedge clk);
        stat_wr_sel = 2'b10; stat_wr_val = 2'd2;
        @(negedge clk);
        stat_wr_sel = 2'b00;
        ctx_state("R11 load", 2'd1, 1'b0, 2'd2, 1'b0);

        // R8 store and no-write arithmetic leave context alone
        req_valid = 1'b1; req_kind = 2'd2; #2;
        chk_eq("R8 store no write", {63'd0, rf_we}, 64'd0);
        chk_eq("R8 store legal", {63'd0, illegal}, 64'd0);
        @(negedge clk);
        req_kind = 2'd3; #2;
        chk_eq("R8 nowr no write", {63'd0, rf_we}, 64'd0);
        @(negedge clk);
        req_valid = 1'b0;
        ctx_state("R8 untouched", 2'd1, 1'b0, 2'd2, 1'b0);

        // R1 single arithmetic write, virt off (R9 off path)
        req_valid = 1'b1; req_kind = 2'd0; req_single = 1'b1; req_wdata = 64'h1234_5678_9ABC_DEF0; virt_on = 1'b0; #2;
        chk_eq("R1 write enable", {63'd0, rf_we}, 64'd1);
        chk_eq("R1 boxed write", rf_wdata, 64'hFFFF_FFFF_9ABC_DEF0);
        @(negedge clk);
        req_valid = 1'b0;
        ctx_state("R8 R9 dirty main only", 2'd3, 1'b1, 2'd2, 1'b0);

        // R2 double load
        req_valid = 1'b1; req_kind = 2'd1; req_single = 1'b0; req_wdata = 64'h0123_4567_89AB_CDEF; #2;
        chk_eq("R2 wide write", rf_wdata, 64'h0123_4567_89AB_CDEF);
        chk_eq("R2 write enable", {63'd0, rf_we}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;

        // R11 reload clean, then load and write together with virt on
        stat_wr_sel = 2'b11; stat_wr_val = 2'd2;
        @(negedge clk);
        ctx_state("R11 clean reload", 2'd2, 1'b0, 2'd2, 1'b0);
        stat_wr_sel = 2'b11; stat_wr_val = 2'd1;
        req_valid = 1'b1; req_kind = 2'd1; req_single = 1'b1; virt_on = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; stat_wr_sel = 2'b00;
        ctx_state("R9 R11 dirty wins", 2'd3, 1'b1, 2'd3, 1'b1);

        // R11 loading the dirty value sets summary
        stat_wr_sel = 2'b01; stat_wr_val = 2'd1;
        @(negedge clk);
        stat_wr_val = 2'd3;
        @(negedge clk);
        stat_wr_sel = 2'b00;
        chk_eq("R11 load dirty summary", {63'd0, sd_main}, 64'd1);

        // R10 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ctx_state("R10 rerun reset", 2'd0, 1'b0, 2'd0, 1'b0);

        finish_up();
    end
endmodule